// File: doc/BRIEF.md
# Complex 2x2 Triangular Reducer

This block takes a complex 2x2 fixed-point matrix and turns it into a real upper-triangular matrix R. It does this with five unitary CORDIC rotations applied in a fixed order. Along the way it builds a left transform Q and a right transform W, which satisfy Q·A·W = R up to rounding. Its outputs are meant for a following real 2x2 SVD stage, which is not part of this block.

Each step first runs a vectoring CORDIC on one target element. For a phase step the pair is the target's real and imaginary part. For the Givens step the pair is two real entries in one column. The vectoring CORDIC records one direction bit per micro-rotation, plus a half-turn flag used when the x input is negative. The same decisions are then replayed by rotation CORDICs on every other element that the step affects. The target keeps its gain-corrected magnitude, and the component that was nulled is written as an exact zero.

Both sides use a valid/ready handshake. A transfer happens only on a clock edge where both valid and ready are high. One step runs per clock cycle. The block holds its result until the output is taken, and it accepts a new matrix only while idle.

Top module: `cplx_tri_reducer`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and every output word is 0.
- R2: A matrix is captured only on an edge where `in_valid` and `in_ready` are both 1. From the capture edge until the output is released, `in_ready` stays 0, and any `in_valid` during that time is ignored and has no effect on the result.
- R3: `out_valid` first reads 1 right after the fifth clock edge that follows the capture edge. `in_ready` returns the cycle after the output handshake. With `out_ready` held at 1, matrices are accepted every 7 cycles.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and all three output matrices stay stable.
- R5: In R, the imaginary parts of all four entries are exactly 0, the entry at row 2 column 1 is exactly 0, and the real parts of entries 11, 12 and 22 are not negative.
- R6: W is diag(1, phase). Its entry 11 is exactly `2^(DW-2)`, and its entries 12 and 21 are exactly 0.
- R7 (word order): Each matrix bus packs eight DW-bit two's-complement words. Word index = 4·row + 2·col + part, where part 0 is the real part and part 1 the imaginary part. Word 0 sits at the least significant bits.
- R7 (step order): The steps run in this order: null the phase of A11 (row 1, Q row 1); null the phase of A21 (row 2, Q row 2); apply the real Givens on rows 1–2 that zeroes A21 (also on Q rows); null the phase of A12 (column 2, W column 2); null the phase of A22 (Q row 2).
- R7 (arithmetic): Each CORDIC first negates its pair if x < 0. It then runs ITER micro-rotations. In micro-rotation i the direction is "clockwise" when y ≥ 0, and the update is x' = x ± (y>>>i), y' = y ∓ (x>>>i). The result is scaled as (v·19898 + 16384) >>> 15.
- R8: If a step's target pair is exactly (0,0), that step leaves every other element unchanged and writes the target as 0.
- R9: Q and W restart from the identity for every matrix, with unity encoded as `2^(DW-2)`. Inputs must satisfy |part| < 2^(DW-3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input matrix valid |
| in_ready | output | 1 | Block idle and able to capture |
| in_mat | input | 8*DW | Complex input matrix A |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_r | output | 8*DW | Real upper-triangular result R |
| out_q | output | 8*DW | Accumulated left transform Q |
| out_w | output | 8*DW | Accumulated right transform W |

## Verification
The bench pushes target elements with negative real parts, pure imaginary targets and all-zero targets through the reducer. A missing half-turn pre-rotation would leave R with negative or wrongly signed diagonal values. A missing zero-target bypass would spin Q by an arbitrary angle on the zero matrix. Each case is compared bit for bit with an independent step model.

Back-to-back matrices, a zero matrix that follows non-trivial ones, and a long stall on the output are also covered. These expose transforms that carry over from the previous matrix, an off-by-one in the step counter, and results that drift while held. Input presented while the block is busy checks that stray captures cannot corrupt the matrix in flight.

// File: rtl/svdr_pkg.sv
package svdr_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_HOLD = 2'd2} svdr_state_e;

  typedef logic signed [47:0] wide_t;

  localparam int KINV_Q15   = 19898;
  localparam int KSHIFT     = 15;
  localparam int ROUND_HALF = 1 << (KSHIFT - 1);
  localparam int NELEM      = 8;
  localparam int NROT       = 6;

  // scale a CORDIC output by the reciprocal gain, rounded
  function automatic wide_t gain_fix(wide_t v);
    wide_t p;
    p = v * wide_t'(KINV_Q15);
    p = p + wide_t'(ROUND_HALF);
    return p >>> KSHIFT;
  endfunction
endpackage

// File: rtl/svdr_vec.sv
module svdr_vec
  import svdr_pkg::*;
#(
  parameter int DW   = 16,
  parameter int ITER = 14,
  parameter int IW   = DW + 3
) (
  input  logic signed [DW-1:0] vx_i,
  input  logic signed [DW-1:0] vy_i,
  output logic [ITER-1:0]      dir_o,
  output logic                 flip_o,
  output logic                 skip_o,
  output logic signed [DW-1:0] mag_o
);
  always_comb begin
    logic signed [IW-1:0] x, y, xn;
    x      = IW'(vx_i);
    y      = IW'(vy_i);
    skip_o = (vx_i == '0) && (vy_i == '0);
    flip_o = x < 0;
    if (flip_o) begin
      x = -x;
      y = -y;
    end
    for (int i = 0; i < ITER; i++) begin
      dir_o[i] = (y >= 0);
      if (dir_o[i]) begin
        xn = x + (y >>> i);
        y  = y - (x >>> i);
      end else begin
        xn = x - (y >>> i);
        y  = y + (x >>> i);
      end
      x = xn;
    end
    mag_o = DW'(gain_fix(wide_t'(x)));
  end
endmodule

// File: rtl/svdr_rot.sv
module svdr_rot
  import svdr_pkg::*;
#(
  parameter int DW   = 16,
  parameter int ITER = 14,
  parameter int IW   = DW + 3
) (
  input  logic signed [DW-1:0] rx_i,
  input  logic signed [DW-1:0] ry_i,
  input  logic [ITER-1:0]      dir_i,
  input  logic                 flip_i,
  input  logic                 skip_i,
  output logic signed [DW-1:0] ox_o,
  output logic signed [DW-1:0] oy_o
);
  always_comb begin
    logic signed [IW-1:0] x, y, xn;
    x = IW'(rx_i);
    y = IW'(ry_i);
    if (flip_i) begin
      x = -x;
      y = -y;
    end
    for (int i = 0; i < ITER; i++) begin
      if (dir_i[i]) begin
        xn = x + (y >>> i);
        y  = y - (x >>> i);
      end else begin
        xn = x - (y >>> i);
        y  = y + (x >>> i);
      end
      x = xn;
    end
    if (skip_i) begin
      ox_o = rx_i;
      oy_o = ry_i;
    end else begin
      ox_o = DW'(gain_fix(wide_t'(x)));
      oy_o = DW'(gain_fix(wide_t'(y)));
    end
  end
endmodule

// File: rtl/cplx_tri_reducer.sv
module cplx_tri_reducer
  import svdr_pkg::*;
#(
  parameter int DW   = 16,
  parameter int ITER = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [8*DW-1:0]   in_mat,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [8*DW-1:0]   out_r,
  output logic [8*DW-1:0]   out_q,
  output logic [8*DW-1:0]   out_w
);
  localparam int IW = DW + 3;
  localparam int LAST_STEP = 4;
  localparam logic signed [DW-1:0] ONE = {2'b01, {(DW-2){1'b0}}};

  svdr_state_e state_q;
  logic [2:0] step_q;
  logic signed [DW-1:0] a [NELEM];
  logic signed [DW-1:0] q [NELEM];
  logic signed [DW-1:0] w [NELEM];

  logic signed [DW-1:0] vx, vy, vmag;
  logic [ITER-1:0] vdir;
  logic vflip, vskip;
  logic signed [DW-1:0] rx [NROT];
  logic signed [DW-1:0] ry [NROT];
  logic signed [DW-1:0] ox [NROT];
  logic signed [DW-1:0] oy [NROT];

  // named events
  logic accept, step_fire, last_step, release_ev;
  assign in_ready   = (state_q == ST_IDLE);
  assign out_valid  = (state_q == ST_HOLD);
  assign step_fire  = (state_q == ST_RUN);
  assign accept     = in_valid && in_ready;
  assign last_step  = step_fire && (step_q == 3'(LAST_STEP));
  assign release_ev = out_valid && out_ready;

  // operand routing per step
  always_comb begin
    vx = '0;
    vy = '0;
    for (int k = 0; k < NROT; k++) begin
      rx[k] = '0;
      ry[k] = '0;
    end
    case (step_q)
      3'd0: begin
        vx = a[0]; vy = a[1];
        rx[0] = a[2]; ry[0] = a[3];
        rx[1] = q[0]; ry[1] = q[1];
        rx[2] = q[2]; ry[2] = q[3];
      end
      3'd1: begin
        vx = a[4]; vy = a[5];
        rx[0] = a[6]; ry[0] = a[7];
        rx[1] = q[4]; ry[1] = q[5];
        rx[2] = q[6]; ry[2] = q[7];
      end
      3'd2: begin
        vx = a[0]; vy = a[4];
        rx[0] = a[2]; ry[0] = a[6];
        rx[1] = a[3]; ry[1] = a[7];
        rx[2] = q[0]; ry[2] = q[4];
        rx[3] = q[1]; ry[3] = q[5];
        rx[4] = q[2]; ry[4] = q[6];
        rx[5] = q[3]; ry[5] = q[7];
      end
      3'd3: begin
        vx = a[2]; vy = a[3];
        rx[0] = a[6]; ry[0] = a[7];
        rx[1] = w[2]; ry[1] = w[3];
        rx[2] = w[6]; ry[2] = w[7];
      end
      default: begin
        vx = a[6]; vy = a[7];
        rx[0] = q[4]; ry[0] = q[5];
        rx[1] = q[6]; ry[1] = q[7];
      end
    endcase
  end

  svdr_vec #(.DW(DW), .ITER(ITER), .IW(IW)) u_vec (
    .vx_i(vx), .vy_i(vy), .dir_o(vdir), .flip_o(vflip), .skip_o(vskip), .mag_o(vmag)
  );

  for (genvar k = 0; k < NROT; k++) begin : g_rot
    svdr_rot #(.DW(DW), .ITER(ITER), .IW(IW)) u_rot (
      .rx_i(rx[k]), .ry_i(ry[k]), .dir_i(vdir), .flip_i(vflip), .skip_i(vskip),
      .ox_o(ox[k]), .oy_o(oy[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      for (int e = 0; e < NELEM; e++) begin
        a[e] <= '0;
        q[e] <= '0;
        w[e] <= '0;
      end
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          for (int e = 0; e < NELEM; e++) begin
            a[e] <= in_mat[e*DW +: DW];
            q[e] <= (e == 0 || e == 6) ? ONE : '0;
            w[e] <= (e == 0 || e == 6) ? ONE : '0;
          end
          step_q  <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          case (step_q)
            3'd0: begin
              a[0] <= vmag;  a[1] <= '0;
              a[2] <= ox[0]; a[3] <= oy[0];
              q[0] <= ox[1]; q[1] <= oy[1];
              q[2] <= ox[2]; q[3] <= oy[2];
            end
            3'd1: begin
              a[4] <= vmag;  a[5] <= '0;
              a[6] <= ox[0]; a[7] <= oy[0];
              q[4] <= ox[1]; q[5] <= oy[1];
              q[6] <= ox[2]; q[7] <= oy[2];
            end
            3'd2: begin
              a[0] <= vmag;  a[4] <= '0;
              a[2] <= ox[0]; a[6] <= oy[0];
              a[3] <= ox[1]; a[7] <= oy[1];
              q[0] <= ox[2]; q[4] <= oy[2];
              q[1] <= ox[3]; q[5] <= oy[3];
              q[2] <= ox[4]; q[6] <= oy[4];
              q[3] <= ox[5]; q[7] <= oy[5];
            end
            3'd3: begin
              a[2] <= vmag;  a[3] <= '0;
              a[6] <= ox[0]; a[7] <= oy[0];
              w[2] <= ox[1]; w[3] <= oy[1];
              w[6] <= ox[2]; w[7] <= oy[2];
            end
            default: begin
              a[6] <= vmag;  a[7] <= '0;
              q[4] <= ox[0]; q[5] <= oy[0];
              q[6] <= ox[1]; q[7] <= oy[1];
            end
          endcase
          if (last_step) state_q <= ST_HOLD;
          else           step_q  <= step_q + 3'd1;
        end
        ST_HOLD: if (release_ev) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar e = 0; e < NELEM; e++) begin : g_pack
    assign out_r[e*DW +: DW] = a[e];
    assign out_q[e*DW +: DW] = q[e];
    assign out_w[e*DW +: DW] = w[e];
  end

  // R2
  state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({in_ready, step_fire, out_valid}));

  // R2
  busy_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##5 !out_valid ##1 out_valid);

  // R3
  ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> in_ready);

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_r) && $stable(out_q) && $stable(out_w)));

  // R5
  real_triangular_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (a[1] == '0 && a[3] == '0 && a[4] == '0 && a[5] == '0 && a[7] == '0
                          && a[0] >= 0 && a[2] >= 0 && a[6] >= 0));

  // R6
  right_diag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (w[0] == ONE && w[1] == '0 && w[2] == '0 && w[3] == '0
                   && w[4] == '0 && w[5] == '0));
endmodule

// File: tb/cplx_tri_reducer_bench.sv
module cplx_tri_reducer_bench;
  localparam int DW = 16;
  localparam int ITER = 14;
  localparam longint ONE = 64'sd16384;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [8*DW-1:0] in_mat = '0;
  logic in_ready, out_valid;
  logic [8*DW-1:0] out_r, out_q, out_w;

  cplx_tri_reducer #(.DW(DW), .ITER(ITER)) u_cplx_tri_reducer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_mat(in_mat),
    .out_valid(out_valid), .out_ready(out_ready), .out_r(out_r), .out_q(out_q), .out_w(out_w)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- reference arithmetic ----------------
  function automatic longint scale_back(longint v);
    return (v * 19898 + 16384) >>> 15;
  endfunction

  function automatic void ref_vector(input longint xi, input longint yi, output logic [31:0] d,
                                     output bit fl, output bit sk, output longint m);
    longint x, y, t;
    x = xi; y = yi; d = '0;
    sk = (xi == 0) && (yi == 0);
    fl = (x < 0);
    if (fl) begin x = -x; y = -y; end
    for (int i = 0; i < ITER; i++) begin
      t = x;
      if (y >= 0) begin d[i] = 1'b1; x = x + (y >>> i); y = y - (t >>> i); end
      else        begin              x = x - (y >>> i); y = y + (t >>> i); end
    end
    m = scale_back(x);
  endfunction

  function automatic void ref_turn(input longint xi, input longint yi, input logic [31:0] d,
                                   input bit fl, input bit sk, output longint xo, output longint yo);
    longint x, y, t;
    if (sk) begin xo = xi; yo = yi; return; end
    x = fl ? -xi : xi;
    y = fl ? -yi : yi;
    for (int i = 0; i < ITER; i++) begin
      t = x;
      if (d[i]) begin x = x + (y >>> i); y = y - (t >>> i); end
      else      begin x = x - (y >>> i); y = y + (t >>> i); end
    end
    xo = scale_back(x);
    yo = scale_back(y);
  endfunction

  longint er[8], eq[8], ew[8];

  task automatic ref_reduce(input logic [8*DW-1:0] m);
    logic [31:0] d; bit fl, sk; longint mg;
    for (int e = 0; e < 8; e++) begin
      er[e] = longint'($signed(m[e*DW +: DW]));
      eq[e] = (e == 0 || e == 6) ? ONE : 0;
      ew[e] = (e == 0 || e == 6) ? ONE : 0;
    end
    ref_vector(er[0], er[1], d, fl, sk, mg); er[0] = mg; er[1] = 0;
    ref_turn(er[2], er[3], d, fl, sk, er[2], er[3]);
    ref_turn(eq[0], eq[1], d, fl, sk, eq[0], eq[1]);
    ref_turn(eq[2], eq[3], d, fl, sk, eq[2], eq[3]);
    ref_vector(er[4], er[5], d, fl, sk, mg); er[4] = mg; er[5] = 0;
    ref_turn(er[6], er[7], d, fl, sk, er[6], er[7]);
    ref_turn(eq[4], eq[5], d, fl, sk, eq[4], eq[5]);
    ref_turn(eq[6], eq[7], d, fl, sk, eq[6], eq[7]);
    ref_vector(er[0], er[4], d, fl, sk, mg); er[0] = mg; er[4] = 0;
    ref_turn(er[2], er[6], d, fl, sk, er[2], er[6]);
    ref_turn(er[3], er[7], d, fl, sk, er[3], er[7]);
    for (int c = 0; c < 4; c++) ref_turn(eq[c], eq[c+4], d, fl, sk, eq[c], eq[c+4]);
    ref_vector(er[2], er[3], d, fl, sk, mg); er[2] = mg; er[3] = 0;
    ref_turn(er[6], er[7], d, fl, sk, er[6], er[7]);
    ref_turn(ew[2], ew[3], d, fl, sk, ew[2], ew[3]);
    ref_turn(ew[6], ew[7], d, fl, sk, ew[6], ew[7]);
    ref_vector(er[6], er[7], d, fl, sk, mg); er[6] = mg; er[7] = 0;
    ref_turn(eq[4], eq[5], d, fl, sk, eq[4], eq[5]);
    ref_turn(eq[6], eq[7], d, fl, sk, eq[6], eq[7]);
  endtask

  // ---------------- cycle model ----------------
  int m_state = 0;   // 0 idle, 1 working, 2 holding
  int m_cnt = 0;
  bit m_held = 0;
  bit m_fresh = 0;
  int acc_cyc[$];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_held = 0;
    end else begin
      case (m_state)
        0: if (in_valid) begin
             ref_reduce(in_mat); m_state = 1; m_cnt = 0; acc_cyc.push_back(cyc);
           end
        1: begin m_cnt++; if (m_cnt == 5) begin m_state = 2; m_fresh = 1; m_held = 0; end end
        default: if (out_ready) m_state = 0; else m_held = 1;
      endcase
    end
  end

  function automatic longint word(input logic [8*DW-1:0] bus, input int e);
    return longint'($signed(bus[e*DW +: DW]));
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk(in_ready === (m_state == 0), "R2", "in_ready", longint'(in_ready), longint'(m_state == 0));
      chk(out_valid === (m_state == 2), "R3", "out_valid", longint'(out_valid), longint'(m_state == 2));
      if (m_state == 2 && out_valid) begin
        for (int e = 0; e < 8; e++) begin
          chk(word(out_r, e) == er[e], m_held ? "R4" : "R7", $sformatf("R word %0d", e), word(out_r, e), er[e]);
          chk(word(out_q, e) == eq[e], m_held ? "R4" : "R7", $sformatf("Q word %0d", e), word(out_q, e), eq[e]);
          chk(word(out_w, e) == ew[e], m_held ? "R4" : "R7", $sformatf("W word %0d", e), word(out_w, e), ew[e]);
        end
        if (m_fresh) begin
          m_fresh = 0;
          for (int e = 1; e < 8; e += 2)
            chk(word(out_r, e) == 0, "R5", $sformatf("imag word %0d", e), word(out_r, e), 0);
          chk(word(out_r, 4) == 0, "R5", "r21 real", word(out_r, 4), 0);
          chk(word(out_r, 0) >= 0 && word(out_r, 2) >= 0 && word(out_r, 6) >= 0, "R5",
              "sign of r11", word(out_r, 0), 0);
          chk(word(out_w, 0) == ONE, "R6", "w11", word(out_w, 0), ONE);
          chk(word(out_w, 2) == 0 && word(out_w, 4) == 0, "R6", "w12", word(out_w, 2), 0);
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL R3 watchdog: cycles %0d expected below 50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [8*DW-1:0] mk(input int v0, v1, v2, v3, v4, v5, v6, v7);
    logic [8*DW-1:0] m;
    m[0*DW +: DW] = DW'(v0); m[1*DW +: DW] = DW'(v1);
    m[2*DW +: DW] = DW'(v2); m[3*DW +: DW] = DW'(v3);
    m[4*DW +: DW] = DW'(v4); m[5*DW +: DW] = DW'(v5);
    m[6*DW +: DW] = DW'(v6); m[7*DW +: DW] = DW'(v7);
    return m;
  endfunction

  int unsigned seed = 32'h1234_5678;
  function automatic int rnd_part();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % 8001) - 4000;
  endfunction

  task automatic send(input logic [8*DW-1:0] m);
    @(posedge clk); #1;
    in_valid = 1'b1; in_mat = m;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_out();
    do @(negedge clk); while (!out_valid);
    @(posedge clk); #1;
  endtask

  initial begin
    int lat;
    repeat (4) @(posedge clk);
    // R1 reset state
    @(negedge clk);
    chk(in_ready === 1'b1, "R1", "in_ready in reset", longint'(in_ready), 1);
    chk(out_valid === 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    chk(out_r == '0, "R1", "out_r in reset", word(out_r, 0), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // general matrix, latency R3
    send(mk(3000, 2000, -1500, 700, -2500, 1200, 800, -3100));
    lat = 0;
    do begin @(negedge clk); lat++; end while (!out_valid && lat < 20);
    chk(lat == 6, "R3", "negedges from capture to valid", lat, 6);
    @(posedge clk); #1;

    // back to back, period R3
    send(mk(4000, 0, 0, 0, 0, 0, 4000, 0));
    send(mk(-3500, -200, 1000, -3900, 2500, -2500, -100, 50));
    chk(acc_cyc[$] - acc_cyc[$-1] == 7, "R3", "capture period", acc_cyc[$] - acc_cyc[$-1], 7);
    wait_out();

    // backpressure R4
    out_ready = 1'b0;
    send(mk(0, -3000, 0, 2000, 0, 1500, 0, -2500));
    repeat (14) @(negedge clk);
    chk(out_valid === 1'b1, "R4", "valid held", longint'(out_valid), 1);
    @(posedge clk); #1 out_ready = 1'b1;
    wait_out();

    // input ignored while busy R2
    send(mk(-1200, 3300, 2100, -400, -3800, -900, 1700, 2600));
    in_valid = 1'b1; in_mat = mk(111, 222, 333, 444, 555, 666, 777, 888);
    repeat (3) @(posedge clk);
    #1 in_valid = 1'b0;
    wait_out();

    // zero matrix after non-trivial ones: R8, R9
    send('0);
    do @(negedge clk); while (!out_valid);
    chk(out_r == '0, "R8", "zero matrix R", word(out_r, 0), 0);
    chk(word(out_q, 0) == ONE && word(out_q, 6) == ONE, "R9", "Q diagonal", word(out_q, 0), ONE);
    chk(word(out_q, 2) == 0 && word(out_q, 4) == 0 && word(out_q, 1) == 0 && word(out_q, 7) == 0,
        "R8", "Q untouched", word(out_q, 2), 0);
    chk(word(out_w, 6) == ONE && word(out_w, 7) == 0, "R9", "W w22", word(out_w, 6), ONE);
    @(posedge clk); #1;

    // zero target only in first column: R8 on step 1 and 2
    send(mk(0, 0, 2000, -1000, 0, 0, -3000, 500));
    wait_out();

    // pseudo-random matrices
    for (int n = 0; n < 24; n++) begin
      send(mk(rnd_part(), rnd_part(), rnd_part(), rnd_part(),
              rnd_part(), rnd_part(), rnd_part(), rnd_part()));
      if (n % 5 == 2) begin
        out_ready = 1'b0;
        repeat (3) @(posedge clk);
        #1 out_ready = 1'b1;
      end
      wait_out();
    end

    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule